// File: doc/BRIEF.md
# Speculative Line Prefetch Controller

This block sits beside a one-line read buffer that serves bus-master reads of main memory. While a master streams a read out of the buffer, the controller decides whether to ask the memory side for the following cache line ahead of demand. It also keeps the tag and valid state of the buffer. The request goes out only when a set of conditions all hold: the command type is eligible, the read began at the start of a line, the read has reached the trigger doubleword, no write-side flush is waiting, and the target is main memory rather than ROM. A line is 32 bytes, made of four 8-byte doublewords.

The prefetch request is a valid/ready stream carrying a line-aligned address. Once `pf_valid` is raised, it stays high with `pf_addr` unchanged until a cycle in which `pf_ready` is high. That cycle is the handshake. The memory side may hold `pf_ready` low for any number of cycles. When the read moves into the next line (`rd_line_adv`), a held prefetched line becomes the buffer contents. A write that lands on a buffered line invalidates it. Ending the read throws away any prefetched line that was not consumed.

Top module: `spec_prefetch_ctrl`

## Requirements
- R1: Command codes on `rd_cmd` are 2'b00 plain read, 2'b01 read-line, 2'b10 read-multiple and 2'b11 reserved. Read-multiple is always eligible. Plain read and read-line are eligible only when `cfg_spec_all` was 1 at `rd_start`. The reserved code is never eligible.
- R2: A read is eligible only if its start address lies in the first doubleword of its line, that is, address bits [4:3] are zero. Bits [2:0] do not matter.
- R3: A request is raised one cycle after a cycle in which an eligible active read has `rd_dw_idx` equal to 2. That cycle must not also carry `rd_start` or `rd_line_adv`. At most one request is raised per line visit.
- R4: A read whose `rd_is_mem` was 0 at `rd_start` (ROM space) never raises a request.
- R5: No request is raised from a cycle with `flush_pending` high. If the flush clears while the read is still at doubleword 2, the request is raised then. If the read leaves doubleword 2 first, no request is raised for that line.
- R6: `pf_addr` is the current line address plus 32, with bits [4:0] zero. The sum wraps modulo 2^ADDR_W.
- R7: While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_addr` stays stable. While a request is pending, or while a prefetched line is held (`spec_valid`), no new request is raised.
- R8: `rd_start` sets `buf_line` to the start address's line and `buf_valid` to 1. `rd_line_adv` moves `buf_line` up by 32 and sets `buf_valid` to the held state of the prefetched line, then clears `spec_valid`. A request accepted after the read has already entered the requested line sets `buf_valid` directly.
- R9: A write (`wr_valid`) whose line equals `buf_line` clears `buf_valid` on the next cycle. A write to the held prefetched line clears `spec_valid`. Writes to other lines change neither.
- R10: When `rd_active` falls, the held prefetched line is dropped (`spec_valid` 0). A request accepted after the read has ended is not held.
- R11: After reset, `pf_valid`, `buf_valid` and `spec_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_spec_all | input | 1 | Allow speculation for plain read and read-line |
| rd_active | input | 1 | A read transaction is in progress |
| rd_start | input | 1 | First cycle of a read; command, address and space are sampled |
| rd_cmd | input | 2 | Read command code |
| rd_addr | input | ADDR_W | Read start address |
| rd_is_mem | input | 1 | 1 = main memory space, 0 = ROM space |
| rd_dw_idx | input | 2 | Doubleword of the line currently being read |
| rd_line_adv | input | 1 | The read crosses into the next line |
| flush_pending | input | 1 | A write-side buffer flush is waiting |
| wr_valid | input | 1 | A master write is observed |
| wr_addr | input | ADDR_W | Address of the observed write |
| pf_valid | output | 1 | Prefetch request valid |
| pf_ready | input | 1 | Memory side accepts the request |
| pf_addr | output | ADDR_W | Line-aligned prefetch address |
| buf_valid | output | 1 | Read buffer holds valid data for buf_line |
| buf_line | output | ADDR_W | Line address tagged in the read buffer |
| spec_valid | output | 1 | A prefetched next line is held |

## Verification
The bench builds the block with ADDR_W set to 16 and leaves the line and doubleword sizes at their defaults. The narrow address brings the top line of the space (0xFFE0) within reach. There, the next-line address must wrap to 0x0000, which exercises the modular sum of R6. With only four doublewords per line, the bench can walk whole lines across several line advances. It does this with the request port stalled for many cycles to exercise R7, and with flushes that either clear inside the trigger doubleword or outlast it.

// File: rtl/spf_pkg.sv
package spf_pkg;

  typedef enum logic [1:0] {
    CMD_READ      = 2'b00,
    CMD_READ_LINE = 2'b01,
    CMD_READ_MULT = 2'b10,
    CMD_RSVD      = 2'b11
  } rd_cmd_e;

endpackage

// File: rtl/spf_elig.sv
module spf_elig
  import spf_pkg::*;
#(
  parameter int OFF_W    = 5,
  parameter int DW_SHIFT = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_start,
  input  logic [1:0]                rd_cmd,
  input  logic [OFF_W-1:DW_SHIFT]   start_dw,
  input  logic                      rd_is_mem,
  input  logic                      cfg_spec_all,
  output logic                      elig_q
);

  logic aligned;
  logic cmd_ok;

  // start must fall inside the first doubleword of the line
  assign aligned = (start_dw == '0);

  always_comb begin
    unique case (rd_cmd)
      CMD_READ_MULT:          cmd_ok = 1'b1;
      CMD_READ, CMD_READ_LINE: cmd_ok = cfg_spec_all;
      default:                cmd_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        elig_q <= 1'b0;
    else if (rd_start) elig_q <= cmd_ok & aligned & rd_is_mem;
  end

endmodule

// File: rtl/spf_issue.sv
module spf_issue #(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 5,
  parameter int IDX_W    = 2,
  parameter int TRIG_IDX = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      elig_q,
  input  logic                      rd_active,
  input  logic                      rd_start,
  input  logic                      rd_line_adv,
  input  logic [IDX_W-1:0]          rd_dw_idx,
  input  logic                      flush_pending,
  input  logic                      spec_held,
  input  logic [ADDR_W-OFF_W-1:0]   cur_line,
  input  logic                      pf_ready,
  output logic                      pf_valid,
  output logic [ADDR_W-1:0]         pf_addr
);

  localparam int LINE_W = ADDR_W - OFF_W;
  localparam logic [IDX_W-1:0] TRIG = IDX_W'(TRIG_IDX);

  logic              fired_q;
  logic              fire;
  logic [LINE_W-1:0] next_line;

  assign next_line = cur_line + LINE_W'(1);

  assign fire = rd_active && !rd_start && !rd_line_adv && elig_q &&
                (rd_dw_idx == TRIG) && !flush_pending &&
                !pf_valid && !spec_held && !fired_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired_q  <= 1'b0;
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else begin
      if (rd_start || rd_line_adv) fired_q <= 1'b0;
      else if (fire)               fired_q <= 1'b1;

      if (fire) begin
        pf_valid <= 1'b1;
        pf_addr  <= {next_line, {OFF_W{1'b0}}};
      end else if (pf_ready) begin
        pf_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/spf_tag.sv
module spf_tag #(
  parameter int LINE_W = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_active,
  input  logic              rd_start,
  input  logic [LINE_W-1:0] start_line,
  input  logic              rd_line_adv,
  input  logic              pf_accept,
  input  logic [LINE_W-1:0] pf_line,
  input  logic              wr_valid,
  input  logic [LINE_W-1:0] wr_line,
  output logic [LINE_W-1:0] cur_line,
  output logic              buf_valid,
  output logic              spec_held
);

  logic              active_q;
  logic              rd_end;
  logic [LINE_W-1:0] spec_line_q;
  logic              buf_hit;
  logic              spec_hit;
  logic              spec_keep;
  logic [LINE_W-1:0] adv_line;

  assign rd_end    = active_q && !rd_active;
  assign buf_hit   = wr_valid && (wr_line == cur_line);
  assign spec_hit  = wr_valid && (wr_line == spec_line_q);
  assign spec_keep = spec_held && !spec_hit;
  assign adv_line  = cur_line + LINE_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      cur_line    <= '0;
      buf_valid   <= 1'b0;
      spec_held   <= 1'b0;
      spec_line_q <= '0;
    end else begin
      active_q <= rd_active;

      if (rd_start) begin
        cur_line  <= start_line;
        buf_valid <= 1'b1;
        spec_held <= 1'b0;
      end else if (rd_line_adv) begin
        cur_line  <= adv_line;
        buf_valid <= (spec_keep && spec_line_q == adv_line) ||
                     (pf_accept && pf_line == adv_line);
        spec_held <= 1'b0;
      end else if (rd_end) begin
        spec_held <= 1'b0;
        if (buf_hit) buf_valid <= 1'b0;
      end else if (pf_accept) begin
        if (pf_line == cur_line) begin
          buf_valid <= 1'b1;
        end else begin
          spec_held   <= rd_active;
          spec_line_q <= pf_line;
          if (buf_hit) buf_valid <= 1'b0;
        end
      end else begin
        if (buf_hit)  buf_valid <= 1'b0;
        if (spec_hit) spec_held <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/spec_prefetch_ctrl.sv
module spec_prefetch_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int DW_BYTES   = 8,
  parameter int TRIG_IDX   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_spec_all,
  input  logic              rd_active,
  input  logic              rd_start,
  input  logic [1:0]        rd_cmd,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_is_mem,
  input  logic [1:0]        rd_dw_idx,
  input  logic              rd_line_adv,
  input  logic              flush_pending,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr,
  output logic              buf_valid,
  output logic [ADDR_W-1:0] buf_line,
  output logic              spec_valid
);

  localparam int OFF_W    = $clog2(LINE_BYTES);
  localparam int DW_SHIFT = $clog2(DW_BYTES);
  localparam int IDX_W    = OFF_W - DW_SHIFT;
  localparam int LINE_W   = ADDR_W - OFF_W;

  logic              elig_q;
  logic              spec_held;
  logic [LINE_W-1:0] cur_line;
  logic              unused_addr_bits;

  assign unused_addr_bits = ^{rd_addr[DW_SHIFT-1:0], wr_addr[OFF_W-1:0],
                              pf_addr[OFF_W-1:0]};

  spf_elig #(.OFF_W(OFF_W), .DW_SHIFT(DW_SHIFT)) u_elig (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_start     (rd_start),
    .rd_cmd       (rd_cmd),
    .start_dw     (rd_addr[OFF_W-1:DW_SHIFT]),
    .rd_is_mem    (rd_is_mem),
    .cfg_spec_all (cfg_spec_all),
    .elig_q       (elig_q)
  );

  spf_issue #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
              .TRIG_IDX(TRIG_IDX)) u_issue (
    .clk           (clk),
    .rst_n         (rst_n),
    .elig_q        (elig_q),
    .rd_active     (rd_active),
    .rd_start      (rd_start),
    .rd_line_adv   (rd_line_adv),
    .rd_dw_idx     (rd_dw_idx[IDX_W-1:0]),
    .flush_pending (flush_pending),
    .spec_held     (spec_held),
    .cur_line      (cur_line),
    .pf_ready      (pf_ready),
    .pf_valid      (pf_valid),
    .pf_addr       (pf_addr)
  );

  spf_tag #(.LINE_W(LINE_W)) u_tag (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_active   (rd_active),
    .rd_start    (rd_start),
    .start_line  (rd_addr[ADDR_W-1:OFF_W]),
    .rd_line_adv (rd_line_adv),
    .pf_accept   (pf_valid && pf_ready),
    .pf_line     (pf_addr[ADDR_W-1:OFF_W]),
    .wr_valid    (wr_valid),
    .wr_line     (wr_addr[ADDR_W-1:OFF_W]),
    .cur_line    (cur_line),
    .buf_valid   (buf_valid),
    .spec_held   (spec_held)
  );

  assign buf_line   = {cur_line, {OFF_W{1'b0}}};
  assign spec_valid = spec_held;

endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 5,
  parameter int TRIG_IDX = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_spec_all,
  input logic              rd_active,
  input logic              rd_start,
  input logic [1:0]        rd_cmd,
  input logic              rd_is_mem,
  input logic [1:0]        rd_dw_idx,
  input logic              rd_line_adv,
  input logic              flush_pending,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [ADDR_W-1:0] pf_addr,
  input logic              buf_valid,
  input logic [ADDR_W-1:0] buf_line,
  input logic              spec_valid
);

  logic [1:0] cmd_q;
  logic       cfg_q;
  logic       mem_q;
  logic       act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= 2'b11;
      cfg_q <= 1'b0;
      mem_q <= 1'b0;
      act_q <= 1'b0;
    end else begin
      act_q <= rd_active;
      if (rd_start) begin
        cmd_q <= rd_cmd;
        cfg_q <= cfg_spec_all;
        mem_q <= rd_is_mem;
      end
    end
  end

  // R1
  a_r1_cmd_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_valid) |-> (cmd_q == 2'b10 || (cfg_q && cmd_q != 2'b11)));

  // R3
  a_r3_trigger_dw: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_valid) |-> $past(rd_dw_idx) == 2'(TRIG_IDX));

  // R4
  a_r4_mem_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_valid) |-> mem_q);

  // R5
  a_r5_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_valid) |-> !$past(flush_pending));

  // R6
  a_r6_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> pf_addr[OFF_W-1:0] == '0);

  // R7
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));

  // R7
  a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> !spec_valid);

  // R9
  a_r9_wr_invalidate: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && buf_valid && (wr_addr[ADDR_W-1:OFF_W] == buf_line[ADDR_W-1:OFF_W]) &&
    !rd_start && !rd_line_adv && !(pf_valid && pf_ready) |=> !buf_valid);

  // R10
  a_r10_end_discard: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && !rd_active |=> !spec_valid);

endmodule

bind spec_prefetch_ctrl spf_checker #(
  .ADDR_W(ADDR_W), .OFF_W($clog2(LINE_BYTES)), .TRIG_IDX(TRIG_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_spec_all(cfg_spec_all), .rd_active(rd_active),
  .rd_start(rd_start), .rd_cmd(rd_cmd), .rd_is_mem(rd_is_mem),
  .rd_dw_idx(rd_dw_idx), .rd_line_adv(rd_line_adv), .flush_pending(flush_pending),
  .wr_valid(wr_valid), .wr_addr(wr_addr), .pf_valid(pf_valid), .pf_ready(pf_ready),
  .pf_addr(pf_addr), .buf_valid(buf_valid), .buf_line(buf_line),
  .spec_valid(spec_valid)
);

// File: tb/spec_prefetch_ctrl_test.sv
module spec_prefetch_ctrl_test;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_spec_all = 1'b0;
  logic          rd_active = 1'b0;
  logic          rd_start = 1'b0;
  logic [1:0]    rd_cmd = 2'b00;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_is_mem = 1'b1;
  logic [1:0]    rd_dw_idx = 2'd0;
  logic          rd_line_adv = 1'b0;
  logic          flush_pending = 1'b0;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic          pf_valid;
  logic          pf_ready = 1'b1;
  logic [AW-1:0] pf_addr;
  logic          buf_valid;
  logic [AW-1:0] buf_line;
  logic          spec_valid;

  int checks = 0;
  int fails  = 0;
  logic [AW-1:0] exp_q[$];

  always #5 clk = ~clk;

  spec_prefetch_ctrl #(.ADDR_W(AW)) uut (.*);

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor: samples mid-cycle, handshake completes at next edge
  always @(negedge clk) begin
    if (rst_n && pf_valid && pf_ready) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R3: actual unexpected request %h expected none", pf_addr);
      end else begin
        chk("R6", pf_addr, exp_q.pop_front());
      end
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic start_rd(input logic [1:0] cmd, input logic [AW-1:0] a, input logic mem);
    rd_start = 1'b1; rd_active = 1'b1; rd_cmd = cmd; rd_addr = a;
    rd_is_mem = mem; rd_dw_idx = a[4:3];
    tick();
    rd_start = 1'b0;
  endtask

  task automatic step(input logic [1:0] idx);
    rd_dw_idx = idx; tick();
  endtask

  task automatic adv();
    rd_line_adv = 1'b1; rd_dw_idx = 2'd0; tick(); rd_line_adv = 1'b0;
  endtask

  task automatic end_rd();
    rd_active = 1'b0; tick();
  endtask

  task automatic wr(input logic [AW-1:0] a);
    wr_valid = 1'b1; wr_addr = a; tick(); wr_valid = 1'b0;
  endtask

  // one aligned line visit from doubleword 0 (already presented) to 3
  task automatic rest_of_line();
    step(2'd1); step(2'd2); step(2'd3);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(); tick();
    // R11 reset state
    chk("R11", AW'(pf_valid), '0);
    chk("R11", AW'(buf_valid), '0);
    chk("R11", AW'(spec_valid), '0);
    rst_n = 1'b1; tick();

    // R1 read-multiple eligible with cfg off; R8 tag and advance
    exp_q.push_back(16'h1020);
    start_rd(2'b10, 16'h1000, 1'b1);
    chk("R8", AW'(buf_valid), 1);
    chk("R8", buf_line, 16'h1000);
    rest_of_line();
    chk("R7", AW'(spec_valid), 1);
    adv();
    chk("R8", buf_line, 16'h1020);
    chk("R8", AW'(buf_valid), 1);
    chk("R8", AW'(spec_valid), 0);
    exp_q.push_back(16'h1040);
    rest_of_line();
    chk("R3", AW'(spec_valid), 1);
    end_rd();
    chk("R10", AW'(spec_valid), 0);

    // R1 plain read with cfg off: nothing
    start_rd(2'b00, 16'h1100, 1'b1); rest_of_line();
    chk("R1", AW'(pf_valid), 0);
    end_rd();
    // R1 plain and read-line with cfg on; reserved never
    cfg_spec_all = 1'b1;
    exp_q.push_back(16'h1120);
    start_rd(2'b00, 16'h1100, 1'b1); rest_of_line(); end_rd();
    exp_q.push_back(16'h1220);
    start_rd(2'b01, 16'h1200, 1'b1); rest_of_line(); end_rd();
    start_rd(2'b11, 16'h1300, 1'b1); rest_of_line();
    chk("R1", AW'(pf_valid), 0);
    end_rd();
    cfg_spec_all = 1'b0;

    // R2 unaligned start: none; byte offset inside first doubleword: fires
    start_rd(2'b10, 16'h2008, 1'b1); step(2'd2); step(2'd3);
    chk("R2", AW'(pf_valid), 0);
    end_rd();
    exp_q.push_back(16'h2020);
    start_rd(2'b10, 16'h2004, 1'b1); rest_of_line(); end_rd();

    // R4 ROM space
    start_rd(2'b10, 16'h2100, 1'b0); rest_of_line();
    chk("R4", AW'(pf_valid), 0);
    end_rd();

    // R5 flush held over doubleword 2 then cleared there
    start_rd(2'b10, 16'h2200, 1'b1); step(2'd1);
    flush_pending = 1'b1; step(2'd2); step(2'd2);
    chk("R5", AW'(pf_valid), 0);
    exp_q.push_back(16'h2220);
    flush_pending = 1'b0; step(2'd2); step(2'd3);
    end_rd();
    // R5 flush outlasting doubleword 2
    start_rd(2'b10, 16'h2300, 1'b1); step(2'd1);
    flush_pending = 1'b1; step(2'd2); step(2'd3);
    flush_pending = 1'b0; tick();
    chk("R5", AW'(pf_valid), 0);
    end_rd();

    // R7 back-pressure: request held, no second request
    pf_ready = 1'b0;
    start_rd(2'b10, 16'h4000, 1'b1); rest_of_line();
    chk("R7", AW'(pf_valid), 1);
    chk("R7", pf_addr, 16'h4020);
    adv(); step(2'd1); step(2'd2); step(2'd3);
    chk("R7", pf_addr, 16'h4020);
    chk("R7", AW'(pf_valid), 1);
    exp_q.push_back(16'h4020);
    pf_ready = 1'b1; tick();
    chk("R8", AW'(buf_valid), 1);
    chk("R8", AW'(spec_valid), 0);
    end_rd();

    // R6 wrap at the top of the address space
    exp_q.push_back(16'h0000);
    start_rd(2'b10, 16'hFFE0, 1'b1); rest_of_line(); end_rd();

    // R9 write hits
    exp_q.push_back(16'h3020);
    start_rd(2'b10, 16'h3000, 1'b1); rest_of_line();
    wr(16'h5010);
    chk("R9", AW'(buf_valid), 1);
    chk("R9", AW'(spec_valid), 1);
    wr(16'h3010);
    chk("R9", AW'(buf_valid), 0);
    chk("R9", AW'(spec_valid), 1);
    wr(16'h3028);
    chk("R9", AW'(spec_valid), 0);
    adv();
    chk("R9", AW'(buf_valid), 0);
    end_rd();

    // R10 request accepted after the read ended is not held
    pf_ready = 1'b0;
    start_rd(2'b10, 16'h6000, 1'b1); rest_of_line(); end_rd();
    exp_q.push_back(16'h6020);
    pf_ready = 1'b1; tick(); tick();
    chk("R10", AW'(spec_valid), 0);

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R3: actual %0d requests missing expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule